// File: doc/BRIEF.md
# Thermal Throttle Transition Controller

This block governs the operating point of a die under thermal stress. While the die is cool it passes software's nominal operating-point code to a voltage/frequency sequencer. When a digital over-temperature flag rises, it first records the code in use. It then asks the sequencer to move to a reduced frequency/voltage code held in a software-writable register.

Once the sequencer confirms the move, the controller holds the reduced point for a fixed number of cycles and then samples the flag again. If the die has cooled, it asks for the recorded code. If the die is still hot, it starts the wait again. Every completed down move and every completed up move produces a one-cycle interrupt pulse and sets a sticky status bit.

If the sequencer reports that the down move failed, the controller turns on clock-duty throttling instead. Throttling stays on until the flag clears. The physical sensor and the regulators lie outside this block.

Top module: `thermal_step_ctrl`

## Requirements
- R1: After reset, `op_code_o` equals parameter `RESET_OP`, `op_req_o`, `throttle_o` and `irq_o` are 0, `stat_o` is 0, and the reduced-point register holds parameter `LOW_RST`.
- R2: A write to address 1 while idle and not hot sets `op_code_o` to the written value and pulses `op_req_o` for one cycle. A write to address 0 only loads the reduced-point register and issues no request.
- R3: With `hot_i` high while idle, the next cycle shows `op_code_o` equal to the reduced-point register and a one-cycle `op_req_o` pulse. The code in use is recorded at that moment.
- R4: A `seq_done_i` (without `seq_fail_i`) while a down move is pending gives a one-cycle `irq_o` pulse and sets `stat_o[0]` (down bit).
- R5: If `hot_i` is low when the wait ends, `op_req_o` pulses exactly `WAIT_CYC` cycles after the cycle that showed the down-done interrupt, with `op_code_o` equal to the recorded code.
- R6: If `hot_i` is still high when the wait ends, no request is made and the wait restarts. The next evaluation falls `WAIT_CYC` cycles later.
- R7: A `seq_done_i` while an up move is pending gives a one-cycle `irq_o` pulse, sets `stat_o[1]` (up bit) and returns the block to idle.
- R8: Writes to either address during an excursion change neither the recorded code nor `op_code_o`. A write to address 1 outside idle is ignored.
- R9: A `seq_fail_i` while a down move is pending sets `throttle_o` and puts the recorded code back on `op_code_o`. `throttle_o` stays high while `hot_i` is high and falls the cycle after `hot_i` is seen low, which returns the block to idle.
- R10: A write to address 2 clears each `stat_o` bit whose data bit is 1 (bit 0 down, bit 1 up). A bit being set in the same cycle stays set.
- R11: A `seq_fail_i` while an up move is pending puts the reduced code back on `op_code_o` and restarts the wait. If both `seq_done_i` and `seq_fail_i` are high, the failure is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hot_i | input | 1 | Over-temperature flag |
| seq_done_i | input | 1 | Sequencer reports the requested move completed |
| seq_fail_i | input | 1 | Sequencer reports the requested move failed |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 reduced point, 1 nominal point, 2 status clear |
| wr_data_i | input | OP_W | Write data |
| op_code_o | output | OP_W | Target operating-point code |
| op_req_o | output | 1 | One-cycle request strobe to the sequencer |
| throttle_o | output | 1 | Clock-duty throttling enable |
| irq_o | output | 1 | One-cycle interrupt on each completed transition |
| stat_o | output | 2 | Sticky status: bit 0 down done, bit 1 up done |

## Verification
The main down/wait/up cycle is swept over every nominal code of a 4-bit configuration, each paired with a different reduced code. A mismatched save or restore would therefore show up for at least one pair. Even passes let the die cool before the first evaluation, and odd passes keep it hot across one evaluation. Counting the cycles to the up request then tells a correct single wait apart from a missed or doubled restart. Separate runs fail the down move (throttling and its release), fail the up move (retry at the reduced point), and collide a status clear with a status set.

// File: rtl/thermal_step_pkg.sv
// Shared types and register addresses for the thermal throttle controller.
// Assumes a two-bit register address space.
package thermal_step_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DOWN  = 3'd1,
        ST_COOL  = 3'd2,
        ST_UP    = 3'd3,
        ST_THROT = 3'd4
    } tt_state_e;

    localparam logic [1:0] ADDR_LOW = 2'd0;
    localparam logic [1:0] ADDR_NOM = 2'd1;
    localparam logic [1:0] ADDR_CLR = 2'd2;

endpackage

// File: rtl/thermal_regs.sv
// Software-visible storage: the reduced operating-point code, nominal write
// decode, sticky transition status with write-1-clear, and the interrupt pulse.
// Assumes OP_W >= 2 so the status clear mask fits in the write data.
module thermal_regs
    import thermal_step_pkg::*;
#(
    parameter int unsigned     OP_W    = 4,
    parameter logic [OP_W-1:0] LOW_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_addr_i,
    input  logic [OP_W-1:0] wr_data_i,
    input  logic            evt_down_i,
    input  logic            evt_up_i,
    output logic [OP_W-1:0] low_o,
    output logic            nom_wr_o,
    output logic [OP_W-1:0] nom_data_o,
    output logic            irq_o,
    output logic [1:0]      stat_o
);

    logic [OP_W-1:0] low_q;
    logic [1:0]      stat_q;
    logic            irq_q;
    logic [1:0]      clr_mask;
    logic [1:0]      set_mask;

    // Decode the write strobes into a clear mask and a nominal write.
    always_comb begin
        clr_mask   = (wr_en_i && wr_addr_i == ADDR_CLR) ? wr_data_i[1:0] : 2'b00;
        set_mask   = {evt_up_i, evt_down_i};
        nom_wr_o   = wr_en_i && (wr_addr_i == ADDR_NOM);
        nom_data_o = wr_data_i;
    end

    // Hold the reduced operating-point code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= LOW_RST;
        end else if (wr_en_i && wr_addr_i == ADDR_LOW) begin
            low_q <= wr_data_i;
        end
    end

    // Sticky status; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 2'b00;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | set_mask;
        end
    end

    // One-cycle interrupt on either completed transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= evt_down_i | evt_up_i;
        end
    end

    assign low_o  = low_q;
    assign stat_o = stat_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/thermal_wait_timer.sv
// Cool-down timer: a start pulse clears the count, which then climbs to
// WAIT_CYC-1 and saturates. Assumes WAIT_CYC >= 2.
module thermal_wait_timer #(
    parameter int unsigned WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);

    localparam int unsigned CNT_W = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count from zero after each start, holding at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LAST);

endmodule

// File: rtl/thermal_fsm.sv
// Transition sequencing: records the active code, requests the reduced point,
// runs the cool-down check, restores the recorded code, and falls back to
// clock-duty throttling when the down move fails. Assumes the sequencer answers
// each request with done or fail; fail takes priority when both are high.
module thermal_fsm
    import thermal_step_pkg::*;
#(
    parameter int unsigned     OP_W     = 4,
    parameter logic [OP_W-1:0] RESET_OP = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hot_i,
    input  logic            seq_done_i,
    input  logic            seq_fail_i,
    input  logic            nom_wr_i,
    input  logic [OP_W-1:0] nom_data_i,
    input  logic [OP_W-1:0] low_i,
    input  logic            tmr_exp_i,
    output logic            tmr_start_o,
    output logic            evt_down_o,
    output logic            evt_up_o,
    output logic [OP_W-1:0] op_code_o,
    output logic            op_req_o,
    output logic            throttle_o
);

    tt_state_e       state_q;
    logic [OP_W-1:0] op_q;
    logic [OP_W-1:0] saved_q;
    logic [OP_W-1:0] low_cap_q;
    logic            req_q;
    logic            thr_q;
    logic            ok_done;

    // Sequencer completion that is not overridden by a failure.
    assign ok_done = seq_done_i && !seq_fail_i;

    // Transition events and timer restarts.
    always_comb begin
        evt_down_o  = (state_q == ST_DOWN) && ok_done;
        evt_up_o    = (state_q == ST_UP) && ok_done;
        tmr_start_o = evt_down_o
                    || ((state_q == ST_COOL) && tmr_exp_i && hot_i)
                    || ((state_q == ST_UP) && seq_fail_i);
    end

    // State, target code, recorded code, request strobe and throttle enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= RESET_OP;
            saved_q   <= RESET_OP;
            low_cap_q <= RESET_OP;
            req_q     <= 1'b0;
            thr_q     <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (hot_i) begin
                        saved_q   <= op_q;
                        op_q      <= low_i;
                        low_cap_q <= low_i;
                        req_q     <= 1'b1;
                        state_q   <= ST_DOWN;
                    end else if (nom_wr_i) begin
                        op_q  <= nom_data_i;
                        req_q <= 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (seq_fail_i) begin
                        op_q    <= saved_q;
                        thr_q   <= 1'b1;
                        state_q <= ST_THROT;
                    end else if (seq_done_i) begin
                        state_q <= ST_COOL;
                    end
                end
                ST_COOL: begin
                    if (tmr_exp_i && !hot_i) begin
                        op_q    <= saved_q;
                        req_q   <= 1'b1;
                        state_q <= ST_UP;
                    end
                end
                ST_UP: begin
                    if (seq_fail_i) begin
                        op_q    <= low_cap_q;
                        state_q <= ST_COOL;
                    end else if (seq_done_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_THROT: begin
                    if (!hot_i) begin
                        thr_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_code_o  = op_q;
    assign op_req_o   = req_q;
    assign throttle_o = thr_q;

endmodule

// File: rtl/thermal_step_ctrl.sv
// Top level of the thermal throttle transition controller: joins register
// storage, the cool-down timer and the transition sequencing.
// Assumes OP_W >= 2 and WAIT_CYC >= 2.
module thermal_step_ctrl
    import thermal_step_pkg::*;
#(
    parameter int unsigned     OP_W     = 4,
    parameter int unsigned     WAIT_CYC = 50000,
    parameter logic [OP_W-1:0] RESET_OP = '0,
    parameter logic [OP_W-1:0] LOW_RST  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hot_i,
    input  logic            seq_done_i,
    input  logic            seq_fail_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_addr_i,
    input  logic [OP_W-1:0] wr_data_i,
    output logic [OP_W-1:0] op_code_o,
    output logic            op_req_o,
    output logic            throttle_o,
    output logic            irq_o,
    output logic [1:0]      stat_o
);

    logic [OP_W-1:0] low_w;
    logic            nom_wr_w;
    logic [OP_W-1:0] nom_data_w;
    logic            evt_down_w;
    logic            evt_up_w;
    logic            tmr_start_w;
    logic            tmr_exp_w;

    thermal_regs #(
        .OP_W    (OP_W),
        .LOW_RST (LOW_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .evt_down_i (evt_down_w),
        .evt_up_i   (evt_up_w),
        .low_o      (low_w),
        .nom_wr_o   (nom_wr_w),
        .nom_data_o (nom_data_w),
        .irq_o      (irq_o),
        .stat_o     (stat_o)
    );

    thermal_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start_w),
        .expired_o (tmr_exp_w)
    );

    thermal_fsm #(
        .OP_W     (OP_W),
        .RESET_OP (RESET_OP)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_i       (hot_i),
        .seq_done_i  (seq_done_i),
        .seq_fail_i  (seq_fail_i),
        .nom_wr_i    (nom_wr_w),
        .nom_data_i  (nom_data_w),
        .low_i       (low_w),
        .tmr_exp_i   (tmr_exp_w),
        .tmr_start_o (tmr_start_w),
        .evt_down_o  (evt_down_w),
        .evt_up_o    (evt_up_w),
        .op_code_o   (op_code_o),
        .op_req_o    (op_req_o),
        .throttle_o  (throttle_o)
    );

endmodule

// File: rtl/thermal_step_chk.sv
// Port-level properties of the thermal throttle controller, bound to the top.
module thermal_step_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hot_i,
    input logic       op_req_o,
    input logic       throttle_o,
    input logic       irq_o,
    input logic [1:0] stat_o
);

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7
    irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($countones(stat_o) > 0));

    // R9
    thr_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_o |-> !op_req_o);

    // R9
    thr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_o && !hot_i) |=> !throttle_o);

endmodule

bind thermal_step_ctrl thermal_step_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hot_i      (hot_i),
    .op_req_o   (op_req_o),
    .throttle_o (throttle_o),
    .irq_o      (irq_o),
    .stat_o     (stat_o)
);

// File: tb/thermal_step_ctrl_bench.sv
module thermal_step_ctrl_bench;

    localparam int unsigned     OP_W = 4;
    localparam int unsigned     W    = 5;
    localparam logic [OP_W-1:0] RST_OP = 4'd3;
    localparam logic [OP_W-1:0] LOW_R  = 4'd1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hot = 1'b0;
    logic            done = 1'b0;
    logic            fail = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = 2'd0;
    logic [OP_W-1:0] wr_data = '0;
    logic [OP_W-1:0] op_code;
    logic            req;
    logic            thr;
    logic            irq;
    logic [1:0]      stat;

    int nchk = 0;
    int nerr = 0;

    thermal_step_ctrl #(
        .OP_W     (OP_W),
        .WAIT_CYC (W),
        .RESET_OP (RST_OP),
        .LOW_RST  (LOW_R)
    ) u_thermal_step_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hot_i      (hot),
        .seq_done_i (done),
        .seq_fail_i (fail),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .op_code_o  (op_code),
        .op_req_o   (req),
        .throttle_o (thr),
        .irq_o      (irq),
        .stat_o     (stat)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = OP_W'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic seq(input logic d, input logic f);
        done = d; fail = f;
        tick();
        done = 1'b0; fail = 1'b0;
    endtask

    // Count negedges until the request strobe shows; drop hot at drop_at.
    task automatic count_req(input int drop_at, output int k);
        k = 0;
        do begin
            tick();
            k++;
            if (k == drop_at) hot = 1'b0;
        end while (!req && k < 100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int k;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 op", op_code, RST_OP);
        chk("R1 req", req, 0);
        chk("R1 thr", thr, 0);
        chk("R1 irq", irq, 0);
        chk("R1 stat", stat, 0);
        hot = 1'b1; tick();
        chk("R1 low reset value", op_code, LOW_R);
        seq(1'b1, 1'b0);
        hot = 1'b0;
        count_req(0, k);
        chk("R5 first wait", k, W);
        chk("R5 restore reset op", op_code, RST_OP);
        seq(1'b1, 1'b0);
        wr(2'd2, 3);

        // Sweep every nominal code with a distinct reduced code.
        for (int n = 0; n < 16; n++) begin
            wr(2'd0, 15 - n);
            chk("R2 low write no req", req, 0);
            wr(2'd1, n);
            chk("R2 nominal op", op_code, n);
            chk("R2 nominal req", req, 1);
            hot = 1'b1; tick();
            chk("R3 down op", op_code, 15 - n);
            chk("R3 down req", req, 1);
            wr(2'd0, n ^ 5);
            wr(2'd1, 9);
            chk("R8 op held", op_code, 15 - n);
            chk("R8 no req", req, 0);
            seq(1'b1, 1'b0);
            chk("R4 irq", irq, 1);
            chk("R4 stat down", stat, 1);
            if (n % 2 == 0) begin
                hot = 1'b0;
                count_req(0, k);
                chk("R5 wait cycles", k, W);
            end else begin
                count_req(W + 2, k);
                chk("R6 rewait cycles", k, 2 * W);
            end
            chk("R5 R8 restored op", op_code, n);
            wr(2'd2, 1);
            chk("R10 clear down", stat, 0);
            seq(1'b1, 1'b0);
            chk("R7 irq", irq, 1);
            chk("R7 stat up", stat, 2);
            wr(2'd2, 2);
            chk("R10 clear up", stat, 0);
            wr(2'd0, 15 - n);
        end

        // R9 down move fails: throttle until cool.
        wr(2'd0, 7);
        wr(2'd1, 12);
        hot = 1'b1; tick();
        seq(1'b0, 1'b1);
        chk("R9 throttle on", thr, 1);
        chk("R9 op reverted", op_code, 12);
        repeat (3) tick();
        chk("R9 throttle held", thr, 1);
        chk("R9 no irq", stat, 0);
        hot = 1'b0; tick();
        chk("R9 throttle off", thr, 0);
        hot = 1'b1; tick();
        chk("R9 idle again", op_code, 7);
        chk("R9 req again", req, 1);

        // R11 up move fails: back to reduced point, wait again.
        seq(1'b1, 1'b1);
        chk("R11 fail wins", thr, 1);
        hot = 1'b0; tick();
        hot = 1'b1; tick();
        seq(1'b1, 1'b0);
        hot = 1'b0;
        count_req(0, k);
        chk("R11 first up req", op_code, 12);
        seq(1'b0, 1'b1);
        chk("R11 op back low", op_code, 7);
        count_req(0, k);
        chk("R11 retry wait", k, W);
        chk("R11 retry op", op_code, 12);
        seq(1'b1, 1'b0);
        chk("R11 up done", stat, 3);

        // R10 clear colliding with a set.
        wr(2'd2, 3);
        hot = 1'b1; tick();
        done = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'd1;
        tick();
        done = 1'b0; wr_en = 1'b0;
        chk("R10 set wins", stat, 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule